// File: doc/BRIEF.md
# Dual-Target Two-Wire Slave Front End

This block is the bus-facing half of a small sensor-plus-memory device on a two-wire I2C/SMBus segment. It samples the serial clock and data lines with the system clock. It finds START and STOP conditions and collects the first byte of every transfer. That byte is routed to one of two internal targets: a temperature-sensor register file or a serial-presence-detect memory. The upper nibble of the byte is a target code, and the three bits that follow must match the device's strap pins.

After a match the block acknowledges and then moves bytes in either direction. A written byte is handed to the selected backend through a one-cycle write strobe. Before each byte it sends, the block issues a one-cycle read request and takes the answer one cycle later. A read ends when the master does not acknowledge. The data line is open-drain, and it is modelled as an active-high pull-down enable.

Top module: `dual_i2c_slave`

## Requirements
- R1: While reset is asserted and after it is released, sda_oe, wr_strobe and rd_req are 0.
- R2: A START (SDA falling while SCL is high) is recognised in any state, including partway through a byte, and restarts address collection from the first bit.
- R3: Until a START has been seen, clocked bus traffic leaves sda_oe at 0 and produces no wr_strobe or rd_req.
- R4: The first byte after START is taken MSB first as {code[3:0], a2, a1, a0, rw}. If it matches, sda_oe is 1 throughout the high phase of the 9th SCL pulse.
- R5: Code 4'b0011 selects the sensor (target_sel = 0) and code 4'b1010 selects the memory (target_sel = 1). target_sel holds its value for the whole transfer.
- R6: Any other code, or a2..a0 not equal to strap_addr, is not acknowledged. The block then drives nothing and strobes nothing until the next START.
- R7: In write mode every data byte is acknowledged in its 9th SCL pulse. Each byte also produces exactly one single-cycle wr_strobe, with wr_data equal to the byte assembled MSB first.
- R8: In read mode a single-cycle rd_req comes before each byte, once after the address ACK and once after every master ACK. The byte returned on rd_data is sent MSB first, with a 0 bit driven low (sda_oe = 1) and a 1 bit released.
- R9: A master NoACK (SDA high in the 9th pulse of a read byte) makes the block release SDA. It issues no further rd_req and sends no further bits until the next START.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle, so later clocked bits without a new START get no acknowledge.
- R11: sda_oe changes only while SCL is low, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | Pull-down enable for the data line; 1 drives low |
| strap_addr | input | 3 | Device strap pins compared with a2..a0 |
| target_sel | output | 1 | 0 = temperature-sensor target, 1 = memory target |
| wr_strobe | output | 1 | One-cycle pulse for each acknowledged written byte |
| wr_data | output | 8 | Written byte, valid while wr_strobe is 1 |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | 8 | Byte from the backend, valid the cycle after rd_req |

## Verification
A bus edge takes two synchronizer cycles plus one edge-detect cycle to reach the engine, so the ACK drive and each new data bit show up about four system clocks after an SCL fall. A read byte takes about seven, because the rd_data fetch slot sits in between. The bench holds SCL low for fourteen clocks and high for twelve, and it samples SDA in the middle of each high phase, well after every such change has settled. Strobes and requests are gathered into queues and counters every clock and compared once a transfer has ended. The checks for quiet bus and for SDA stability during SCL high run on every clock against what the bench's own model expects.

// File: rtl/dis_pkg.sv
package dis_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_RDW,
      ST_RDL,
      ST_TX,
      ST_MACK
   } dis_state_e;

   localparam int unsigned LINE_SDA = 0;
   localparam int unsigned LINE_SCL = 1;
   localparam int unsigned N_LINES  = 2;
endpackage

// File: rtl/dis_sync.sv
module dis_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dis_bus_cond.sv
module dis_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // a data edge counts as a bus condition only if SCL was high on both samples
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/dis_engine.sv
module dis_engine
   import dis_pkg::*;
#(
   parameter int PRE_W   = 4,
   parameter int STRAP_W = 3,
   parameter int DATA_W  = 8,
   parameter logic [PRE_W-1:0] SENSOR_PRE = 4'b0011,
   parameter logic [PRE_W-1:0] MEM_PRE    = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic               sda_s,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               sda_oe,
   output logic               target_sel,
   output logic               wr_strobe,
   output logic [DATA_W-1:0]  wr_data,
   output logic               rd_req,
   output logic               idle
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   dis_state_e         state;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  shreg;
   logic               is_addr;
   logic               rw_q;

   logic [PRE_W-1:0]   rx_pre;
   logic [STRAP_W-1:0] rx_strap;
   logic               hit_sens;
   logic               hit_mem;
   logic               addr_ok;

   always_comb begin
      rx_pre   = shreg[DATA_W-1 -: PRE_W];
      rx_strap = shreg[STRAP_W:1];
      hit_sens = (rx_pre == SENSOR_PRE);
      hit_mem  = (rx_pre == MEM_PRE);
      addr_ok  = (hit_sens || hit_mem) && (rx_strap == strap_addr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         is_addr    <= 1'b0;
         rw_q       <= 1'b0;
         target_sel <= 1'b0;
         sda_oe     <= 1'b0;
         wr_strobe  <= 1'b0;
         wr_data    <= '0;
         rd_req     <= 1'b0;
      end else begin
         wr_strobe <= 1'b0;
         rd_req    <= 1'b0;
         if (start_det) begin
            state   <= ST_RX;
            cnt     <= '0;
            is_addr <= 1'b1;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && cnt < FULL) begin
                     shreg <= {shreg[DATA_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (is_addr) begin
                        if (addr_ok) begin
                           target_sel <= hit_mem;
                           rw_q       <= shreg[0];
                           sda_oe     <= 1'b1;
                           state      <= ST_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        wr_data   <= shreg;
                        wr_strobe <= 1'b1;
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     is_addr <= 1'b0;
                     cnt     <= '0;
                     if (rw_q) begin
                        rd_req <= 1'b1;
                        state  <= ST_RDW;
                     end else begin
                        state <= ST_RX;
                     end
                  end
               end
               ST_RDW: state <= ST_RDL;
               ST_RDL: begin
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[DATA_W-1];
                  cnt    <= '0;
                  state  <= ST_TX;
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else begin
                        sda_oe <= ~shreg[DATA_W-2];
                        shreg  <= {shreg[DATA_W-2:0], 1'b0};
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise && sda_s) begin
                     state <= ST_IDLE;
                  end else if (scl_fall) begin
                     rd_req <= 1'b1;
                     state  <= ST_RDW;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign idle = (state == ST_IDLE);
endmodule

// File: rtl/dual_i2c_slave.sv
module dual_i2c_slave
   import dis_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_W       = 4,
   parameter int STRAP_W     = 3,
   parameter int DATA_W      = 8,
   parameter logic [PRE_W-1:0] SENSOR_PRE = 4'b0011,
   parameter logic [PRE_W-1:0] MEM_PRE    = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap_addr,
   output logic               target_sel,
   output logic               wr_strobe,
   output logic [DATA_W-1:0]  wr_data,
   output logic               rd_req,
   input  logic [DATA_W-1:0]  rd_data
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SENSOR_PRE == MEM_PRE) begin : g_bad_pre
      $error("target codes must differ");
   end
   if (DATA_W != PRE_W + STRAP_W + 1) begin : g_bad_width
      $error("address byte layout does not fill DATA_W");
   end

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] sync_lines;
   logic scl_sync;
   logic sda_sync;
   logic scl_rise;
   logic scl_fall;
   logic start_det;
   logic stop_det;
   logic eng_idle;

   assign raw_lines[LINE_SCL] = scl_in;
   assign raw_lines[LINE_SDA] = sda_in;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      dis_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_lines[i]),
         .q     (sync_lines[i])
      );
   end

   assign scl_sync = sync_lines[LINE_SCL];
   assign sda_sync = sync_lines[LINE_SDA];

   dis_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_sync),
      .sda_s     (sda_sync),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   dis_engine #(
      .PRE_W      (PRE_W),
      .STRAP_W    (STRAP_W),
      .DATA_W     (DATA_W),
      .SENSOR_PRE (SENSOR_PRE),
      .MEM_PRE    (MEM_PRE)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_s      (sda_sync),
      .strap_addr (strap_addr),
      .rd_data    (rd_data),
      .sda_oe     (sda_oe),
      .target_sel (target_sel),
      .wr_strobe  (wr_strobe),
      .wr_data    (wr_data),
      .rd_req     (rd_req),
      .idle       (eng_idle)
   );
endmodule

// File: rtl/dual_i2c_slave_chk.sv
module dual_i2c_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic idle,
   input logic sda_oe,
   input logic wr_strobe,
   input logic rd_req
);
   // R11: the pull-down only moves on an update taken while SCL was low
   p_oe_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   // R2: a START always frees the line
   p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R10: a STOP always frees the line
   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R3 / R6: an idle engine stays silent unless a START arrives
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start_det) |=> !sda_oe);

   // R7: write strobe lasts one cycle
   p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);

   // R8: read request lasts one cycle
   p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R8: never a read request and a write strobe together
   p_rw_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_strobe && rd_req));
endmodule

bind dual_i2c_slave dual_i2c_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_sync),
   .start_det (start_det),
   .stop_det  (stop_det),
   .idle      (eng_idle),
   .sda_oe    (sda_oe),
   .wr_strobe (wr_strobe),
   .rd_req    (rd_req)
);

// File: tb/tb_dual_i2c_slave.sv
module tb_dual_i2c_slave;
   localparam int CLK_P = 10;
   localparam int HALF  = 12;
   localparam int WD_CYCLES = 150000;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [3:0] C_SENS = 4'b0011;
   localparam logic [3:0] C_MEM  = 4'b1010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_bus;
   logic sda_oe, target_sel, wr_strobe, rd_req;
   logic [7:0] wr_data;
   logic [7:0] rd_data = 8'h00;

   int checks = 0;
   int errs = 0;
   int rd_cnt = 0;
   logic quiet_exp = 1'b0;
   logic done = 1'b0;
   logic prev_scl = 1'b1;
   logic prev_oe = 1'b0;
   logic [8:0] wq[$];

   always #(CLK_P/2) clk = ~clk;

   assign sda_bus = m_sda & ~sda_oe;

   dual_i2c_slave dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (m_scl),
      .sda_in     (sda_bus),
      .sda_oe     (sda_oe),
      .strap_addr (STRAP),
      .target_sel (target_sel),
      .wr_strobe  (wr_strobe),
      .wr_data    (wr_data),
      .rd_req     (rd_req),
      .rd_data    (rd_data)
   );

   function automatic logic [7:0] pattern(input logic t, input int n);
      logic [7:0] nb;
      nb = 8'(n);
      return t ? (8'hA5 ^ (nb * 8'h3C)) : (8'h30 + nb);
   endfunction

   // behavioural backend: answers a request one cycle later
   always @(posedge clk) begin
      if (rd_req) begin
         rd_data <= pattern(target_sel, rd_cnt);
         rd_cnt  <= rd_cnt + 1;
      end
      if (wr_strobe) wq.push_back({target_sel, wr_data});
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // per-clock model comparison
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_scl && prev_scl) chk("R11 sda_oe stable while SCL high", sda_oe, prev_oe);
         if (quiet_exp) chk("R3/R6/R9 line left released", sda_oe, 1'b0);
      end
      prev_scl = m_scl;
      prev_oe  = sda_oe;
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic b, output logic s);
      hold(2);
      m_sda = b;
      hold(HALF);
      m_scl = 1'b1;
      hold(HALF/2);
      s = sda_bus;
      hold(HALF - HALF/2);
      m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
      bit_cycle(1'b1, s);
      ack = ~s;
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, s);
         b[i] = s;
      end
      bit_cycle(~mack, s);
   endtask

   task automatic do_start();
      m_scl = 1'b1; m_sda = 1'b1;
      hold(HALF);
      m_sda = 1'b0;
      hold(HALF);
      m_scl = 1'b0;
   endtask

   task automatic do_rstart();
      hold(2);
      m_sda = 1'b1;
      hold(HALF);
      m_scl = 1'b1;
      hold(HALF);
      m_sda = 1'b0;
      hold(HALF);
      m_scl = 1'b0;
   endtask

   task automatic do_stop();
      hold(2);
      m_sda = 1'b0;
      hold(HALF);
      m_scl = 1'b1;
      hold(HALF);
      m_sda = 1'b1;
      hold(HALF);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired actual %0d expected 0", WD_CYCLES);
         finish_run();
      end
   end

   initial begin
      logic ack, s;
      logic [7:0] b;
      int base, nw;

      // R1: reset state
      hold(5);
      chk("R1 sda_oe in reset", sda_oe, 1'b0);
      chk("R1 wr_strobe in reset", wr_strobe, 1'b0);
      chk("R1 rd_req in reset", rd_req, 1'b0);
      rst_n = 1'b1;
      hold(10);
      chk("R1 sda_oe after reset", sda_oe, 1'b0);

      // R3: traffic without START
      quiet_exp = 1'b1;
      m_scl = 1'b0;
      hold(HALF);
      send_byte({C_SENS, STRAP, 1'b0}, ack);
      chk("R3 no ack without START", ack, 1'b0);
      m_scl = 1'b1;
      hold(HALF);
      chk("R3 no strobes without START", wq.size() + rd_cnt, 0);
      quiet_exp = 1'b0;

      // R4/R5/R7: write two bytes to the sensor
      do_start();
      send_byte({C_SENS, STRAP, 1'b0}, ack);
      chk("R4 sensor address ack", ack, 1'b1);
      chk("R5 target_sel sensor", target_sel, 1'b0);
      send_byte(8'h5A, ack);
      chk("R7 data byte 1 ack", ack, 1'b1);
      send_byte(8'hC3, ack);
      chk("R7 data byte 2 ack", ack, 1'b1);
      do_stop();
      hold(4);
      chk("R7 write strobe count", wq.size(), 2);
      if (wq.size() == 2) begin
         chk("R7 first written byte", wq[0], {1'b0, 8'h5A});
         chk("R7 second written byte", wq[1], {1'b0, 8'hC3});
      end
      nw = wq.size();

      // R10: after STOP, bits without START are ignored
      quiet_exp = 1'b1;
      m_scl = 1'b0;
      hold(HALF);
      send_byte({C_SENS, STRAP, 1'b0}, ack);
      chk("R10 no ack after STOP", ack, 1'b0);
      m_scl = 1'b1;
      hold(HALF);
      quiet_exp = 1'b0;

      // R6: strap mismatch
      quiet_exp = 1'b1;
      do_start();
      send_byte({C_SENS, STRAP ^ 3'b001, 1'b0}, ack);
      chk("R6 strap mismatch nack", ack, 1'b0);
      send_byte(8'hFF, ack);
      chk("R6 data after mismatch nack", ack, 1'b0);
      do_stop();
      // R6: unknown target code
      do_start();
      send_byte({4'b0101, STRAP, 1'b0}, ack);
      chk("R6 unknown code nack", ack, 1'b0);
      do_stop();
      hold(4);
      chk("R6 no write strobes", wq.size(), nw);
      quiet_exp = 1'b0;

      // R2: repeated START partway through the address
      do_start();
      bit_cycle(1'b1, s);
      bit_cycle(1'b0, s);
      bit_cycle(1'b1, s);
      bit_cycle(1'b0, s);
      do_rstart();
      base = rd_cnt;
      send_byte({C_SENS, STRAP, 1'b1}, ack);
      chk("R2 address after repeated START ack", ack, 1'b1);
      chk("R5 target_sel sensor read", target_sel, 1'b0);
      read_byte(1'b0, b);
      chk("R8 sensor read byte", b, pattern(1'b0, base));
      do_stop();
      chk("R9 single request for single byte", rd_cnt - base, 1);

      // R8/R9: three bytes from memory, NoACK on the last
      do_start();
      send_byte({C_MEM, STRAP, 1'b1}, ack);
      chk("R4 memory address ack", ack, 1'b1);
      chk("R5 target_sel memory", target_sel, 1'b1);
      base = rd_cnt;
      for (int k = 0; k < 3; k++) begin
         read_byte(k < 2, b);
         chk("R8 memory read byte", b, pattern(1'b1, base + k));
      end
      quiet_exp = 1'b1;
      read_byte(1'b0, b);
      chk("R9 no bits after NoACK", b, 8'hFF);
      chk("R9 requests stop after NoACK", rd_cnt - base, 3);
      do_stop();
      quiet_exp = 1'b0;

      // R5/R7: write an all-zero byte to the memory
      do_start();
      send_byte({C_MEM, STRAP, 1'b0}, ack);
      chk("R4 memory write address ack", ack, 1'b1);
      send_byte(8'h00, ack);
      chk("R7 zero byte ack", ack, 1'b1);
      do_stop();
      hold(4);
      chk("R7 memory write count", wq.size(), nw + 1);
      if (wq.size() == nw + 1) chk("R5 memory write routed", wq[nw], {1'b1, 8'h00});

      done = 1'b1;
      finish_run();
   end
endmodule